// File: doc/BRIEF.md
# MDIO Management Command Engine

This block runs single management transactions to an external Ethernet PHY over a two-wire MDC/MDIO serial link. The host writes one 32-bit command word that names the operation, the PHY address, the PHY register and, for a write, the data. It also sets a busy flag. The engine then shifts out a complete clause 22 management frame.

On a read, the engine releases the data line at turnaround and collects sixteen bits from the PHY. When the frame ends it clears busy. The same word then shows the read data and a failure flag that tells whether the PHY answered. The host polls the word until busy drops.

MDC is generated from the system clock. A divider input sets the length of each MDC half-period in system clocks. MDC idles low between transactions, and the engine changes MDIO only right after MDC falls, so the PHY always samples a settled line on the rising edge.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset the command word reads zero, MDC is low and the MDIO output enable is low.
- R2: Command word layout: bit 29 busy, bit 28 read-fail, bit 27 read request, bit 26 write request, bits 25:21 PHY address, bits 20:16 register address, bits 15:0 data, bits 31:30 read as zero. A host write that is accepted stores the word and clears read-fail. Busy is set, and a transaction starts, only when bit 29 is written as one together with bit 27 or bit 26.
- R3: The frame is sent in this order: 32 ones, start bits 01, opcode (10 for read, 01 for write), PHY address MSB first, register address MSB first, two turnaround bits, then 16 data bits MSB first. On a write the engine drives all 64 bits, with turnaround 10.
- R4: The MDC half-period is `mdc_div` system clocks, and a value of 0 acts as 1. MDIO never changes while MDC stays high.
- R5: Busy clears exactly 128 x half-period system clocks after the clock edge that accepts the starting write.
- R6: On a read the engine releases MDIO from the first turnaround bit to the end of the frame. It samples the PHY on each MDC rising edge and places the 16 data bits in bits 15:0 when busy clears.
- R7: If the line is not low at the second turnaround bit of a read, read-fail (bit 28) is set when busy clears. Otherwise it is cleared. Write transactions never set it.
- R8: A host write while busy is set is ignored. The running frame and the stored address fields are unaffected.
- R9: While busy is clear, MDC stays low and MDIO is released.
- R10: When both request bits are set, the transaction is a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Host write strobe for the command word |
| cmd_wdata | input | 32 | Command word written by the host |
| mdc_div | input | DIV_W | MDC half-period in system clocks |
| cmd_rdata | output | 32 | Current command/status word |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Data driven toward the PHY |
| mdio_oe | output | 1 | Output enable for mdio_o |
| mdio_i | input | 1 | Sampled state of the MDIO line |

## Verification
The only timed result is the end of a transaction. Busy, read data and read-fail all update on the same clock edge, exactly 128 x half-period clocks after the edge that captured the starting write. The bench counts falling clock edges from that capture edge. It samples busy one edge before the deadline, when busy must still be set, and again at the deadline, when it must have cleared. The data and fail fields are read at that same point.

MDIO stability during MDC high is watched continuously at falling clock edges, where both signals are settled. Frame content is checked by a PHY model that decodes the frame on MDC rising edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  typedef struct packed {
    logic [1:0]  rsvd;
    logic        busy;
    logic        fail;
    logic        rd;
    logic        wr;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] data;
  } cmd_word_t;

  localparam logic [1:0] ST_CODE  = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] TA_WRITE = 2'b10;
  localparam logic [1:0] TA_READ  = 2'b11;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             mdc,
  output logic             rise_tick,
  output logic             fall_tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_m1;
  logic             tick;

  always_comb begin
    half_m1 = (div == '0) ? '0 : div - 1'b1;
    tick    = en && (cnt >= half_m1);
  end

  assign rise_tick = tick && !mdc;
  assign fall_tick = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_pkg::*;
#(
  parameter int PREAMBLE_LEN = 32
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic        op_rd,
  input  logic [4:0]  phy,
  input  logic [4:0]  regad,
  input  logic [15:0] wdata,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        done,
  output logic [15:0] rdata,
  output logic        ta_fail
);
  localparam int FRAME_LEN = PREAMBLE_LEN + 32;
  localparam int IDX_W     = $clog2(FRAME_LEN);
  localparam logic [IDX_W-1:0] TA1_PRE  = IDX_W'(PREAMBLE_LEN + 13);
  localparam logic [IDX_W-1:0] TA1_IDX  = IDX_W'(PREAMBLE_LEN + 14);
  localparam logic [IDX_W-1:0] TA2_IDX  = IDX_W'(PREAMBLE_LEN + 15);
  localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(PREAMBLE_LEN + 16);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);

  logic [FRAME_LEN-1:0] sh;
  logic [IDX_W-1:0]     idx;
  logic                 active;
  logic                 rd_q;
  logic                 oe_q;
  logic [15:0]          cap;
  logic                 ta_bad;
  logic [FRAME_LEN-1:0] frame;

  always_comb begin
    frame = {{PREAMBLE_LEN{1'b1}}, ST_CODE, (op_rd ? OP_READ : OP_WRITE),
             phy, regad, (op_rd ? TA_READ : TA_WRITE),
             (op_rd ? 16'hFFFF : wdata)};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '1;
      idx    <= '0;
      active <= 1'b0;
      rd_q   <= 1'b0;
      oe_q   <= 1'b0;
      cap    <= '0;
      ta_bad <= 1'b0;
    end else if (start) begin
      sh     <= frame;
      idx    <= '0;
      active <= 1'b1;
      rd_q   <= op_rd;
      oe_q   <= 1'b1;
      cap    <= '0;
      ta_bad <= 1'b0;
    end else if (active) begin
      if (fall_tick) begin
        sh <= {sh[FRAME_LEN-2:0], 1'b1};
        if (idx == LAST_IDX) begin
          active <= 1'b0;
          oe_q   <= 1'b0;
        end else begin
          idx <= idx + 1'b1;
        end
        if (rd_q && idx == TA1_PRE) oe_q <= 1'b0;
      end
      if (rise_tick && rd_q) begin
        if (idx == TA2_IDX) ta_bad <= mdio_i;
        if (idx >= DATA_IDX) cap <= {cap[14:0], mdio_i};
      end
    end
  end

  assign mdio_o  = sh[FRAME_LEN-1];
  assign mdio_oe = oe_q;
  assign done    = active && fall_tick && (idx == LAST_IDX);
  assign rdata   = cap;
  assign ta_fail = ta_bad;

  // R6
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    (active && rd_q && idx >= TA1_IDX) |-> !oe_q);

  // R3
  wr_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (active && !rd_q) |-> oe_q);
endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
  import mdio_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int PREAMBLE_LEN = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_we,
  input  logic [31:0]      cmd_wdata,
  input  logic [DIV_W-1:0] mdc_div,
  output logic [31:0]      cmd_rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe,
  input  logic             mdio_i
);
  cmd_word_t   word_q;
  cmd_word_t   wr_w;
  logic        accept;
  logic        go;
  logic        rise_tick;
  logic        fall_tick;
  logic        done;
  logic [15:0] rdata;
  logic        ta_fail;

  always_comb begin
    wr_w   = cmd_word_t'(cmd_wdata);
    accept = cmd_we && !word_q.busy;
    go     = accept && wr_w.busy && (wr_w.rd || wr_w.wr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
    end else if (accept) begin
      word_q      <= wr_w;
      word_q.rsvd <= '0;
      word_q.fail <= 1'b0;
      word_q.busy <= go;
    end else if (done) begin
      word_q.busy <= 1'b0;
      if (word_q.rd) begin
        word_q.fail <= ta_fail;
        word_q.data <= rdata;
      end
    end
  end

  assign cmd_rdata = word_q;

  mdio_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk       (clk),
    .rst       (rst),
    .en        (word_q.busy),
    .div       (mdc_div),
    .mdc       (mdc),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick)
  );

  mdio_frame_engine #(.PREAMBLE_LEN(PREAMBLE_LEN)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .start     (go),
    .op_rd     (wr_w.rd),
    .phy       (wr_w.phy),
    .regad     (wr_w.regad),
    .wdata     (wr_w.data),
    .rise_tick (rise_tick),
    .fall_tick (fall_tick),
    .mdio_i    (mdio_i),
    .mdio_o    (mdio_o),
    .mdio_oe   (mdio_oe),
    .done      (done),
    .rdata     (rdata),
    .ta_fail   (ta_fail)
  );

  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    word_q.busy |=> ($stable(word_q.phy) && $stable(word_q.regad)));

  // R9
  idle_line_chk: assert property (@(posedge clk) disable iff (rst)
    !word_q.busy |-> (!mdc && !mdio_oe));

  // R4
  mdio_settled_chk: assert property (@(posedge clk) disable iff (rst)
    (mdc && $past(mdc)) |-> $stable(mdio_o));

  // R7
  fail_scope_chk: assert property (@(posedge clk) disable iff (rst)
    word_q.fail |-> (word_q.rd && !word_q.busy));
endmodule

// File: tb/mdio_cmd_engine_test.sv
module mdio_cmd_engine_test;
  localparam int DIV_W    = 8;
  localparam int PHY_ADDR = 1;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cmd_we = 1'b0;
  logic [31:0]      cmd_wdata = '0;
  logic [DIV_W-1:0] mdc_div = 8'd2;
  logic [31:0]      cmd_rdata;
  logic             mdc, mdio_o, mdio_oe;
  logic             mdio_line;
  logic             phy_oe = 1'b0;
  logic             phy_val = 1'b1;

  int checks = 0;
  int errors = 0;
  int viol = 0;

  always #10 clk = ~clk;

  assign mdio_line = mdio_oe ? mdio_o : (phy_oe ? phy_val : 1'b1);

  mdio_cmd_engine #(.DIV_W(DIV_W), .PREAMBLE_LEN(32)) uut (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .mdc_div(mdc_div), .cmd_rdata(cmd_rdata), .mdc(mdc),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_line)
  );

  // PHY model: clause 22 responder with 32 registers
  logic [15:0] phy_regs [32];
  logic [0:63] fr;
  int          ones = 0;
  int          pos = -1;
  int          last_ones = 0;
  logic [1:0]  last_op = '0;
  logic        rd_hit = 1'b0;
  logic [15:0] rd_word = '0;

  function automatic logic [4:0] fld5(input int base);
    logic [4:0] v = '0;
    for (int i = 0; i < 5; i++) v = {v[3:0], fr[base+i]};
    return v;
  endfunction

  always @(posedge mdc) begin
    if (pos < 0) begin
      if (mdio_line) ones++;
      else begin
        if (ones >= 32) begin
          last_ones = ones;
          fr[32] = 1'b0;
          pos = 33;
        end
        ones = 0;
      end
    end else begin
      fr[pos] = mdio_line;
      pos++;
      if (pos == 46) begin
        rd_hit  = ({fr[34], fr[35]} == 2'b10) && (fld5(36) == 5'(PHY_ADDR));
        rd_word = phy_regs[fld5(41)];
      end
      if (pos == 64) begin
        last_op = {fr[34], fr[35]};
        if (last_op == 2'b01 && fld5(36) == 5'(PHY_ADDR)) begin
          logic [15:0] d = '0;
          for (int i = 48; i < 64; i++) d = {d[14:0], fr[i]};
          phy_regs[fld5(41)] = d;
        end
        pos = -1;
        rd_hit = 1'b0;
      end
    end
  end

  always @(negedge mdc) begin
    phy_oe  = rd_hit && pos >= 47 && pos <= 63;
    phy_val = (pos == 47) ? 1'b0 : rd_word[(63 - pos) & 15];
  end

  // MDIO must hold while MDC is high
  logic prev_mdc = 1'b0, prev_o = 1'b1;
  always @(negedge clk) begin
    if (mdc && prev_mdc && mdio_o !== prev_o) viol++;
    prev_mdc = mdc;
    prev_o   = mdio_o;
  end

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic b, input logic r, input logic w,
                                     input logic [4:0] p, input logic [4:0] g,
                                     input logic [15:0] d);
    return {2'b00, b, 1'b0, r, w, p, g, d};
  endfunction

  task automatic do_cmd(input logic [31:0] w, input int half, input string req);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = w;
    @(negedge clk); cmd_we = 1'b0;
    repeat (128*half - 1) @(negedge clk);
    check(req, "busy before deadline", 32'(cmd_rdata[29]), 32'd1);
    @(negedge clk);
    check(req, "busy at deadline", 32'(cmd_rdata[29]), 32'd0);
  endtask

  // {rd, phy, reg, wdata, exp_fail, exp_data}
  localparam logic [43:0] VEC [0:6] = '{
    {1'b0, 5'd1, 5'd3,  16'hA5C3, 1'b0, 16'hA5C3},
    {1'b1, 5'd1, 5'd3,  16'h0000, 1'b0, 16'hA5C3},
    {1'b0, 5'd1, 5'd31, 16'hFFFF, 1'b0, 16'hFFFF},
    {1'b1, 5'd1, 5'd31, 16'h0000, 1'b0, 16'hFFFF},
    {1'b0, 5'd1, 5'd0,  16'h0000, 1'b0, 16'h0000},
    {1'b1, 5'd1, 5'd0,  16'h5555, 1'b0, 16'h0000},
    {1'b1, 5'd5, 5'd2,  16'h0000, 1'b1, 16'hFFFF}
  };

  initial begin
    for (int i = 0; i < 32; i++) phy_regs[i] = 16'h0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1", "word after reset", cmd_rdata, 32'h0);
    check("R1", "mdc after reset", 32'(mdc), 32'd0);
    check("R1", "oe after reset", 32'(mdio_oe), 32'd0);

    for (int v = 0; v < 7; v++) begin
      logic        rd  = VEC[v][43];
      logic [4:0]  p   = VEC[v][42:38];
      logic [4:0]  g   = VEC[v][37:33];
      logic [15:0] wd  = VEC[v][32:17];
      logic        ef  = VEC[v][16];
      logic [15:0] ed  = VEC[v][15:0];
      do_cmd(mk(1'b1, rd, !rd, p, g, wd), 2, "R5");
      check(rd ? "R7" : "R7", "fail flag", 32'(cmd_rdata[28]), 32'(ef));
      if (rd && !ef) check("R6", "read data", 32'(cmd_rdata[15:0]), 32'(ed));
      if (!rd) begin
        check("R3", "phy register written", 32'(phy_regs[g]), 32'(wd));
        check("R3", "opcode seen", 32'(last_op), 32'd1);
        check("R3", "preamble length", last_ones, 32);
      end else begin
        check("R3", "read opcode seen", 32'(last_op), 32'd2);
      end
      check("R9", "mdc idle", 32'(mdc), 32'd0);
      check("R9", "oe idle", 32'(mdio_oe), 32'd0);
    end

    // R10: both request bits -> read
    phy_regs[7] = 16'h1234;
    do_cmd(mk(1'b1, 1'b1, 1'b1, 5'd1, 5'd7, 16'hBEEF), 2, "R10");
    check("R10", "read data", 32'(cmd_rdata[15:0]), 32'h1234);
    check("R10", "opcode on wire", 32'(last_op), 32'd2);
    check("R10", "register untouched", 32'(phy_regs[7]), 32'h1234);

    // R2: busy without request bit starts nothing
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = mk(1'b1, 1'b0, 1'b0, 5'd4, 5'd9, 16'h0F0F);
    @(negedge clk); cmd_we = 1'b0;
    check("R2", "stored word, no busy", cmd_rdata, mk(1'b0, 1'b0, 1'b0, 5'd4, 5'd9, 16'h0F0F));
    repeat (20) @(negedge clk);
    check("R2", "mdc stays low", 32'(mdc), 32'd0);
    // R2: reserved bits and fail bit written as one read back zero
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = 32'hD000_0001;
    @(negedge clk); cmd_we = 1'b0;
    check("R2", "reserved/fail not stored", cmd_rdata, 32'h0000_0001);

    // R8: write during busy ignored
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = mk(1'b1, 1'b0, 1'b1, 5'd1, 5'd9, 16'hC0DE);
    @(negedge clk); cmd_we = 1'b0;
    repeat (50) @(negedge clk);
    cmd_we = 1'b1; cmd_wdata = mk(1'b1, 1'b1, 1'b0, 5'd2, 5'd10, 16'h7777);
    @(negedge clk); cmd_we = 1'b0;
    repeat (256 - 1 - 51) @(negedge clk);
    check("R8", "still busy", 32'(cmd_rdata[29]), 32'd1);
    @(negedge clk);
    check("R8", "done on time", 32'(cmd_rdata[29]), 32'd0);
    check("R8", "fields kept", 32'(cmd_rdata[25:0]), 32'(mk(1'b0, 1'b0, 1'b1, 5'd1, 5'd9, 16'hC0DE) & 32'h03FF_FFFF));
    check("R8", "original write landed", 32'(phy_regs[9]), 32'hC0DE);
    check("R8", "second command absent", 32'(phy_regs[10]), 32'h0);

    // R4/R5: other divider values
    mdc_div = 8'd3;
    do_cmd(mk(1'b1, 1'b1, 1'b0, 5'd1, 5'd9, 16'h0), 3, "R4");
    check("R4", "read at div 3", 32'(cmd_rdata[15:0]), 32'hC0DE);
    mdc_div = 8'd0;
    do_cmd(mk(1'b1, 1'b1, 1'b0, 5'd1, 5'd3, 16'h0), 1, "R4");
    check("R4", "read at div 0", 32'(cmd_rdata[15:0]), 32'hA5C3);

    // R7: fail cleared by next accepted write after a failed read
    do_cmd(mk(1'b1, 1'b1, 1'b0, 5'd9, 5'd1, 16'h0), 1, "R7");
    check("R7", "fail set, absent phy", 32'(cmd_rdata[28]), 32'd1);
    @(negedge clk); cmd_we = 1'b1; cmd_wdata = mk(1'b0, 1'b0, 1'b0, 5'd1, 5'd1, 16'h0);
    @(negedge clk); cmd_we = 1'b0;
    check("R7", "fail cleared on write", 32'(cmd_rdata[28]), 32'd0);

    check("R4", "mdio moved while mdc high", viol, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule